// File: doc/BRIEF.md
# Posted-Write Bus to Serial Transaction Bridge

This bridge sits between a parallel on-chip bus and a downstream serial engine. Bus commands flow in one direction only, from the bus toward the serial side, while data travels both ways. A write command is accepted and finished on the bus as soon as it is placed in a 64-byte posted-write buffer of sixteen 32-bit entries. The serial engine drains that buffer later, one entry at a time. A read command holds the bus until its data has returned from the serial side.

An arbiter owns the single serial request channel. A pending read goes ahead of buffered writes. The exception is a read whose word address matches a write still held in the buffer. That read waits until no held entry matches, and then reads over the serial side. It never takes data from the buffer.

Top module: `bus2ser_bridge`

## Requirements
- R1: After reset `ser_valid`, `resp_valid` and `resp_last` are low, and `cmd_accept` is high for a write because the buffer is empty.
- R2: A write is accepted in the same cycle that `cmd_valid` is presented, as long as the buffer has a free entry and no read is outstanding. No response is returned for a write.
- R3: The buffer holds 16 entries (64 bytes). While 16 entries are held, a write is not accepted. It is accepted once the serial engine acknowledges the oldest entry.
- R4: Buffered writes appear on the serial side in arrival order. `ser_write`=1 and the address, data and size are unchanged.
- R5: A serial request keeps `ser_valid` high with stable `ser_write`, `ser_addr`, `ser_data_out` and `ser_size` until `ser_ack`. A buffer entry is freed only by that acknowledge.
- R6: `ser_start` is high in exactly the first cycle of each serial request.
- R7: From the cycle a read is accepted until its serial acknowledge, `cmd_accept` stays low for any command.
- R8: One cycle after the acknowledge of a serial read, `resp_valid` and `resp_last` pulse high for one cycle, with `resp_data` equal to `ser_data_in` as it was at that acknowledge.
- R9: A read whose address bits [31:2] match no buffered entry is issued as soon as the serial channel is free, ahead of every buffered write. A request already in flight is never preempted.
- R10: A read whose address bits [31:2] match a buffered entry is issued only after every matching entry has been acknowledged. It is issued before any later non-matching write, and its data comes from the serial side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Bus command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Byte address of the command |
| cmd_wdata | input | 32 | Write data |
| cmd_size | input | 2 | Transfer size code, forwarded unchanged |
| cmd_accept | output | 1 | Command taken this cycle when `cmd_valid` is high |
| resp_valid | output | 1 | Read data strobe |
| resp_data | output | 32 | Read data |
| resp_last | output | 1 | Last transfer of the read response |
| ser_valid | output | 1 | Serial request active |
| ser_start | output | 1 | First cycle of a serial request |
| ser_write | output | 1 | 1 = write request, 0 = read request |
| ser_addr | output | 32 | Serial request address |
| ser_data_out | output | 32 | Serial write data |
| ser_size | output | 2 | Serial request size code |
| ser_ack | input | 1 | Serial engine finished the current request |
| ser_data_in | input | 32 | Read data, valid with `ser_ack` |

## Verification
A corrupted buffer pointer or occupancy count shows up at the ports within one serial transaction. Writes then arrive out of order or duplicated in the serial log, or `cmd_accept` rises while sixteen entries are still held. A wrong match vector shows up as a read issued before its matching write has been acknowledged, or as a read that sits behind unrelated writes. The bench tells these apart by the order of the logged serial requests and by the response data, which the responder derives from the address and never from the write data. A stuck read-pending flag shows up at once as `cmd_accept` staying low, or rising before the read data has come back.

// File: rtl/bridge_pkg.sv
// Shared widths, buffer entry layout and serial operation codes for the bridge.
package bridge_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SIZE_W-1:0] size;
    } wq_ent_t;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } ser_op_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Posted-write buffer: first-in first-out storage of address, data and size.
// Every occupied entry's word address is compared with a probe word address
// in the same cycle. Assumes push is never raised while full and pop never
// while empty.
module wbuf_fifo
    import bridge_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  wq_ent_t              push_ent,
    input  logic                 pop,
    output wq_ent_t              head,
    output logic                 full,
    output logic                 empty,
    input  logic [ADDR_W-3:0]    probe_word,
    output logic                 hit
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    wq_ent_t             mem [DEPTH];
    logic [DEPTH-1:0]    occ;
    logic [DEPTH-1:0]    match;
    logic [PTR_W-1:0]    wr_ptr;
    logic [PTR_W-1:0]    rd_ptr;
    logic [CNT_W-1:0]    cnt;

    // Entry storage: written on push, needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    // Pointers, occupancy count and per-entry occupied flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                occ[wr_ptr] <= 1'b1;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                occ[rd_ptr] <= 1'b0;
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // One word-address comparator per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = occ[i] && (mem[i].addr[ADDR_W-1:2] == probe_word);
    end

    // Status and head outputs.
    always_comb begin
        hit   = |match;
        head  = mem[rd_ptr];
        full  = (cnt == CNT_W'(DEPTH));
        empty = (cnt == '0);
    end
endmodule

// File: rtl/rd_track.sv
// Read tracker: holds the single outstanding read, reports whether it still
// needs the serial channel, and registers the response strobe and data.
// Assumes acc_rd is raised only while no read is pending.
module rd_track
    import bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_rd,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [SIZE_W-1:0]    cmd_size,
    input  logic                 issue_rd,
    input  logic                 done_rd,
    input  logic [DATA_W-1:0]    done_data,
    output logic                 rd_pend,
    output logic                 rd_want,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [SIZE_W-1:0]    rd_size,
    output logic                 resp_valid,
    output logic [DATA_W-1:0]    resp_data,
    output logic                 resp_last
);
    logic issued;

    // Outstanding-read state and the registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend    <= 1'b0;
            issued     <= 1'b0;
            rd_addr    <= '0;
            rd_size    <= '0;
            resp_valid <= 1'b0;
            resp_last  <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= done_rd;
            resp_last  <= done_rd;
            if (done_rd) begin
                resp_data <= done_data;
                rd_pend   <= 1'b0;
                issued    <= 1'b0;
            end
            if (issue_rd) begin
                issued <= 1'b1;
            end
            if (acc_rd) begin
                rd_pend <= 1'b1;
                issued  <= 1'b0;
                rd_addr <= cmd_addr;
                rd_size <= cmd_size;
            end
        end
    end

    // The read still needs the serial channel.
    assign rd_want = rd_pend && !issued;
endmodule

// File: rtl/ser_arb.sv
// Serial arbiter: owns the single request channel toward the serial engine.
// A waiting read without a buffer hit wins over the buffer head. A request is
// held unchanged until ser_ack, and the channel stays idle for one cycle
// between requests.
module ser_arb
    import bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_want,
    input  logic                 rd_hit,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [SIZE_W-1:0]    rd_size,
    input  logic                 wq_empty,
    input  wq_ent_t              wq_head,
    input  logic                 ser_ack,
    output logic                 ser_valid,
    output logic                 ser_start,
    output logic                 ser_write,
    output logic [ADDR_W-1:0]    ser_addr,
    output logic [DATA_W-1:0]    ser_data_out,
    output logic [SIZE_W-1:0]    ser_size,
    output logic                 issue_rd,
    output logic                 wq_pop,
    output logic                 rd_done
);
    logic    busy;
    ser_op_e cur_op;
    logic    pick_rd;
    logic    pick_wr;

    // Selection while idle, and completion decode while busy.
    always_comb begin
        pick_rd  = !busy && rd_want && !rd_hit;
        pick_wr  = !busy && !pick_rd && !wq_empty;
        issue_rd = pick_rd;
        wq_pop   = busy && ser_ack && (cur_op == OP_WR);
        rd_done  = busy && ser_ack && (cur_op == OP_RD);
    end

    // Request registers: loaded on selection, released on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            ser_start    <= 1'b0;
            cur_op       <= OP_RD;
            ser_addr     <= '0;
            ser_data_out <= '0;
            ser_size     <= '0;
        end else begin
            ser_start <= 1'b0;
            if (busy && ser_ack) begin
                busy <= 1'b0;
            end
            if (pick_rd) begin
                busy         <= 1'b1;
                ser_start    <= 1'b1;
                cur_op       <= OP_RD;
                ser_addr     <= rd_addr;
                ser_data_out <= '0;
                ser_size     <= rd_size;
            end else if (pick_wr) begin
                busy         <= 1'b1;
                ser_start    <= 1'b1;
                cur_op       <= OP_WR;
                ser_addr     <= wq_head.addr;
                ser_data_out <= wq_head.data;
                ser_size     <= wq_head.size;
            end
        end
    end

    assign ser_valid = busy;
    assign ser_write = (cur_op == OP_WR);
endmodule

// File: rtl/bus2ser_bridge.sv
// Top of the bus-to-serial bridge. Decodes command acceptance and ties the
// posted-write buffer, the read tracker and the serial arbiter together.
// Assumes one command per cycle at most and a serial engine that raises
// ser_ack for one cycle per request.
module bus2ser_bridge
    import bridge_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [31:0]          cmd_addr,
    input  logic [31:0]          cmd_wdata,
    input  logic [1:0]           cmd_size,
    output logic                 cmd_accept,
    output logic                 resp_valid,
    output logic [31:0]          resp_data,
    output logic                 resp_last,
    output logic                 ser_valid,
    output logic                 ser_start,
    output logic                 ser_write,
    output logic [31:0]          ser_addr,
    output logic [31:0]          ser_data_out,
    output logic [1:0]           ser_size,
    input  logic                 ser_ack,
    input  logic [31:0]          ser_data_in
);
    localparam int WQ_DEPTH = BUF_BYTES / (DATA_W / 8);

    logic              acc_wr;
    logic              acc_rd;
    logic              wq_full;
    logic              wq_empty;
    logic              wq_pop;
    logic              rd_hit;
    logic              rd_pend;
    logic              rd_want;
    logic              issue_rd;
    logic              rd_done;
    logic [ADDR_W-1:0] rd_addr;
    logic [SIZE_W-1:0] rd_size;
    wq_ent_t           wq_head;
    wq_ent_t           new_ent;

    // Acceptance: no command during an outstanding read, no write when full.
    always_comb begin
        cmd_accept = !rd_pend && (!cmd_write || !wq_full);
        acc_wr     = cmd_valid && cmd_accept && cmd_write;
        acc_rd     = cmd_valid && cmd_accept && !cmd_write;
        new_ent    = '{addr: cmd_addr, data: cmd_wdata, size: cmd_size};
    end

    wbuf_fifo #(.DEPTH(WQ_DEPTH)) u_wq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (acc_wr),
        .push_ent   (new_ent),
        .pop        (wq_pop),
        .head       (wq_head),
        .full       (wq_full),
        .empty      (wq_empty),
        .probe_word (rd_addr[ADDR_W-1:2]),
        .hit        (rd_hit)
    );

    rd_track u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .cmd_addr   (cmd_addr),
        .cmd_size   (cmd_size),
        .issue_rd   (issue_rd),
        .done_rd    (rd_done),
        .done_data  (ser_data_in),
        .rd_pend    (rd_pend),
        .rd_want    (rd_want),
        .rd_addr    (rd_addr),
        .rd_size    (rd_size),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .resp_last  (resp_last)
    );

    ser_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_want      (rd_want),
        .rd_hit       (rd_hit),
        .rd_addr      (rd_addr),
        .rd_size      (rd_size),
        .wq_empty     (wq_empty),
        .wq_head      (wq_head),
        .ser_ack      (ser_ack),
        .ser_valid    (ser_valid),
        .ser_start    (ser_start),
        .ser_write    (ser_write),
        .ser_addr     (ser_addr),
        .ser_data_out (ser_data_out),
        .ser_size     (ser_size),
        .issue_rd     (issue_rd),
        .wq_pop       (wq_pop),
        .rd_done      (rd_done)
    );
endmodule

// File: rtl/bridge_chk.sv
// Protocol checker for the bridge, bound to the top. It tracks its own buffer
// occupancy and outstanding-read flag from port activity only.
module bridge_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_write,
    input logic        cmd_accept,
    input logic        ser_valid,
    input logic        ser_start,
    input logic        ser_write,
    input logic [31:0] ser_addr,
    input logic [31:0] ser_data_out,
    input logic [1:0]  ser_size,
    input logic        ser_ack,
    input logic        resp_valid,
    input logic        resp_last,
    input logic        rd_hit
);
    logic [7:0] occ_cnt;
    logic       rd_out;
    logic       wr_in;
    logic       wr_out;
    logic       rd_fin;

    // Port-level events.
    always_comb begin
        wr_in  = cmd_valid && cmd_accept && cmd_write;
        wr_out = ser_valid && ser_ack && ser_write;
        rd_fin = ser_valid && ser_ack && !ser_write;
    end

    // Shadow occupancy and outstanding-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_cnt <= '0;
            rd_out  <= 1'b0;
        end else begin
            occ_cnt <= occ_cnt + 8'(wr_in) - 8'(wr_out);
            if (cmd_valid && cmd_accept && !cmd_write) begin
                rd_out <= 1'b1;
            end else if (rd_fin) begin
                rd_out <= 1'b0;
            end
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= 8'(DEPTH));

    p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid && !ser_ack |=> ser_valid && $stable(ser_addr) && $stable(ser_write)
                                  && $stable(ser_data_out) && $stable(ser_size));

    p_start_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> ser_start);

    p_start_only_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> $rose(ser_valid));

    p_read_blocks_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> !(cmd_valid && cmd_accept));

    p_resp_follows_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fin |=> resp_valid && resp_last);

    p_resp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_no_read_on_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start && !ser_write |-> !rd_hit);
endmodule

bind bus2ser_bridge bridge_chk #(.DEPTH(WQ_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_accept   (cmd_accept),
    .ser_valid    (ser_valid),
    .ser_start    (ser_start),
    .ser_write    (ser_write),
    .ser_addr     (ser_addr),
    .ser_data_out (ser_data_out),
    .ser_size     (ser_size),
    .ser_ack      (ser_ack),
    .resp_valid   (resp_valid),
    .resp_last    (resp_last),
    .rd_hit       (rd_hit)
);

// File: tb/bus2ser_bridge_tb_top.sv
`timescale 1ns/100ps
module bus2ser_bridge_tb_top;
    localparam real CLK_P = 5.0;
    localparam int  LAT   = 2;
    localparam int  NVEC  = 6;
    // Each vector: {address, write data, size}
    localparam logic [65:0] WR_VEC [NVEC] = '{
        {32'h0000_0040, 32'h1111_2222, 2'd2},
        {32'h0000_0044, 32'hDEAD_BEEF, 2'd1},
        {32'h0000_0081, 32'h0000_00A5, 2'd0},
        {32'h0000_00C0, 32'hFFFF_0000, 2'd3},
        {32'h8000_0000, 32'h0123_4567, 2'd2},
        {32'hFFFF_FFFC, 32'h89AB_CDEF, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic [1:0]  cmd_size = '0;
    logic        cmd_accept;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        resp_last;
    logic        ser_valid;
    logic        ser_start;
    logic        ser_write;
    logic [31:0] ser_addr;
    logic [31:0] ser_data_out;
    logic [1:0]  ser_size;
    logic        ser_ack = 1'b0;
    logic [31:0] ser_data_in = '0;

    int n_chk = 0;
    int n_err = 0;
    bit stall = 1'b0;
    int start_cnt = 0;
    int log_n = 0;
    bit          lg_w [64];
    logic [31:0] lg_a [64];
    logic [31:0] lg_d [64];
    logic [1:0]  lg_s [64];
    int hold_bad = 0;
    int rd_blk_bad = 0;

    always #(CLK_P / 2.0) clk = ~clk;

    bus2ser_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
        .cmd_accept(cmd_accept), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_last(resp_last), .ser_valid(ser_valid), .ser_start(ser_start),
        .ser_write(ser_write), .ser_addr(ser_addr), .ser_data_out(ser_data_out),
        .ser_size(ser_size), .ser_ack(ser_ack), .ser_data_in(ser_data_in)
    );

    function automatic logic [31:0] rfun(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial responder: acknowledges after LAT extra cycles, logs every request.
    initial begin : responder
        int wc;
        logic [31:0] ca;
        logic [31:0] cd;
        logic [1:0]  cs;
        bit          cw;
        wc = 0;
        ca = '0; cd = '0; cs = '0; cw = 1'b0;
        forever begin
            @(negedge clk);
            ser_ack = 1'b0;
            if (ser_start) begin
                start_cnt++;
                ca = ser_addr; cd = ser_data_out; cs = ser_size; cw = ser_write;
            end
            if (!ser_valid) begin
                wc = 0;
            end else if (!stall) begin
                if (wc >= LAT) begin
                    ser_ack = 1'b1;
                    ser_data_in = ser_write ? 32'h0 : rfun(ser_addr);
                    if (log_n < 64) begin
                        lg_w[log_n] = ser_write; lg_a[log_n] = ser_addr;
                        lg_d[log_n] = ser_data_out; lg_s[log_n] = ser_size;
                    end
                    log_n++;
                    if (ca != ser_addr || cd != ser_data_out || cs != ser_size || cw != ser_write)
                        hold_bad++;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
        end
    end

    // Present one command and wait until it is accepted; returns waited cycles.
    task automatic drive_cmd(input bit w, input logic [31:0] a, input logic [31:0] d,
                             input logic [1:0] s, output int waits);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_size = s;
        waits = 0;
        forever begin
            #1;
            if (cmd_accept || waits > 5000) break;
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    // Issue a read, probe acceptance while it is outstanding, return its data.
    task automatic do_read(input logic [31:0] a, output logic [31:0] d);
        int w;
        int g;
        drive_cmd(1'b0, a, 32'h0, 2'd2, w);
        g = 0;
        forever begin
            @(negedge clk);
            if (resp_valid || g > 5000) break;
            cmd_valid = 1'b1; cmd_write = 1'b0;
            #1;
            if (cmd_accept) rd_blk_bad++;
            cmd_valid = 1'b0;
            g++;
        end
        d = resp_data;
        chk(resp_last === 1'b1, "R8 resp_last with data", 32'(resp_last), 32'd1);
        @(negedge clk);
        chk(resp_valid === 1'b0, "R8 single-cycle resp_valid", 32'(resp_valid), 32'd0);
    endtask

    task automatic wait_log(input int n);
        int g;
        g = 0;
        while (log_n < n && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_log(input int i, input bit w, input logic [31:0] a,
                           input string req);
        chk(lg_w[i] == w && lg_a[i] == a, req, lg_a[i], a);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin : watchdog
        #(200000 * CLK_P);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int w;
        int base;
        logic [31:0] d;

        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmd_write = 1'b1;
        #1;
        chk(ser_valid === 1'b0, "R1 ser_valid after reset", 32'(ser_valid), 32'd0);
        chk(resp_valid === 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 32'd0);
        chk(resp_last === 1'b0, "R1 resp_last after reset", 32'(resp_last), 32'd0);
        chk(cmd_accept === 1'b1, "R1 accept write when empty", 32'(cmd_accept), 32'd1);

        // Vector table: posted writes, then order and field checks on the serial log
        base = log_n;
        for (int i = 0; i < NVEC; i++) begin
            drive_cmd(1'b1, WR_VEC[i][65:34], WR_VEC[i][33:2], WR_VEC[i][1:0], w);
            chk(w == 0, "R2 posted write accepted at once", 32'(w), 32'd0);
        end
        wait_log(base + NVEC);
        for (int i = 0; i < NVEC; i++) begin
            chk(lg_w[base+i] == 1'b1 && lg_a[base+i] == WR_VEC[i][65:34],
                "R4 write order/address", lg_a[base+i], WR_VEC[i][65:34]);
            chk(lg_d[base+i] == WR_VEC[i][33:2], "R4 write data", lg_d[base+i], WR_VEC[i][33:2]);
            chk(lg_s[base+i] == WR_VEC[i][1:0], "R4 write size", 32'(lg_s[base+i]),
                32'(WR_VEC[i][1:0]));
        end
        chk(start_cnt == log_n, "R6 one start per request", 32'(start_cnt), 32'(log_n));

        // R3: fill all 16 entries with the serial side stalled
        stall = 1'b1;
        base = log_n;
        for (int i = 0; i < 16; i++) begin
            drive_cmd(1'b1, 32'h1000 + 32'(i * 4), 32'hF000_0000 + 32'(i), 2'd3, w);
            chk(w == 0, "R3 entry accepted below capacity", 32'(w), 32'd0);
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 32'h1040;
        cmd_wdata = 32'hF000_0010; cmd_size = 2'd3;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(cmd_accept === 1'b0, "R3 write refused when full", 32'(cmd_accept), 32'd0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(log_n == base, "R5 no removal without ack", 32'(log_n), 32'(base));
        stall = 1'b0;
        drive_cmd(1'b1, 32'h1040, 32'hF000_0010, 2'd3, w);
        chk(w > 0, "R3 write accepted after an entry drains", 32'(w), 32'd1);
        wait_log(base + 17);
        for (int i = 0; i < 17; i++) begin
            chk_log(base + i, 1'b1, 32'h1000 + 32'(i * 4), "R4 order after full");
        end
        chk(hold_bad == 0, "R5 request stable until ack", 32'(hold_bad), 32'd0);

        // R9: read with no match overtakes buffered writes
        stall = 1'b1;
        base = log_n;
        for (int i = 0; i < 4; i++) drive_cmd(1'b1, 32'h100 + 32'(i * 4), 32'hAA00 + 32'(i), 2'd2, w);
        fork
            begin repeat (8) @(negedge clk); stall = 1'b0; end
            do_read(32'h200, d);
        join
        chk(d == rfun(32'h200), "R8 read data from serial side", d, rfun(32'h200));
        wait_log(base + 5);
        chk_log(base + 0, 1'b1, 32'h100, "R9 in-flight write not preempted");
        chk_log(base + 1, 1'b0, 32'h200, "R9 read overtakes buffered writes");
        chk_log(base + 2, 1'b1, 32'h104, "R9 writes resume after read");
        chk_log(base + 4, 1'b1, 32'h10C, "R9 last write");

        // R10: read matching a buffered word waits for it, then precedes later writes
        stall = 1'b1;
        base = log_n;
        for (int i = 0; i < 4; i++) drive_cmd(1'b1, 32'h300 + 32'(i * 4), 32'hBB00 + 32'(i), 2'd2, w);
        fork
            begin repeat (8) @(negedge clk); stall = 1'b0; end
            do_read(32'h306, d);
        join
        chk(d == rfun(32'h306), "R10 data read over serial, not forwarded", d, rfun(32'h306));
        wait_log(base + 5);
        chk_log(base + 0, 1'b1, 32'h300, "R10 older write first");
        chk_log(base + 1, 1'b1, 32'h304, "R10 matching write before read");
        chk_log(base + 2, 1'b0, 32'h306, "R10 read right after match drains");
        chk_log(base + 3, 1'b1, 32'h308, "R10 later write after read");

        // R7/R8: read on an idle buffer
        do_read(32'h4444_0010, d);
        chk(d == rfun(32'h4444_0010), "R8 idle read data", d, rfun(32'h4444_0010));
        chk(rd_blk_bad == 0, "R7 no accept while read outstanding", 32'(rd_blk_bad), 32'd0);
        chk(start_cnt == log_n, "R6 starts match requests", 32'(start_cnt), 32'(log_n));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule